// File: doc/BRIEF.md
# Serial PHY Management Master

This block issues single register reads and writes to an external PHY over a two-wire management link: a master-driven clock and one bidirectional data line. The host presents a request strobe together with a read/write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. When the frame is over, the block returns 16 bits of read data and an error flag, and it marks completion with a one-cycle done pulse.

The management clock comes from a divider of the system clock. Each low phase and each high phase of the clock lasts `DIV` system cycles. Every frame has exactly 64 clock slots. The first 32 slots are a preamble of ones. Then come 14 header slots carrying the start code, the opcode and the two addresses. The last 18 slots are either the write tail or the read response. The data output and its output-enable change only while the clock is low. Reads hand the line to the PHY and take it back without any clock edge. The tristate pad sits outside the block. Only one transaction is in flight at a time.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever idle, `mdc` is low, `mdo` is high, `mdo_oe` is high and `busy` is low.
- R2: Each frame produces exactly 64 rising edges of `mdc`. At the first 32 rising edges (the preamble), `mdo_oe` and `mdo` are both high.
- R3: Rising edges 32..45 carry, MSB first, the start code `01`, then the opcode (`10` for read, `01` for write), then the 5-bit PHY address, then the 5-bit register address.
- R4: `mdo` and `mdo_oe` never change in the cycle where `mdc` rises. Each low phase and each high phase of `mdc` lasts `DIV` system cycles, so a frame holds `mdc` high for 64*`DIV` cycles in total.
- R5: In a write (`rd_nwr`=0), rising edges 46..63 carry the turnaround pattern `10` and then the 16 write-data bits MSB first, and `mdo_oe` stays high for the whole frame.
- R6: In a read (`rd_nwr`=1), `mdo_oe` is high for rising edges 0..45 and low for rising edges 46..63. It changes only while `mdc` is low, and it is high again when `done` is asserted.
- R7: In a read, `mdi` is sampled once while `mdc` is low just before rising edge 47; this sample becomes the error indicator, with high meaning that no PHY answered. `mdi` is then sampled just before rising edges 48..63, and these 16 samples form `rdata` MSB first.
- R8: If the error indicator is high, `rdata` returns 0 and `err` is 1. A write returns `rdata`=0 and `err`=0. `rdata` and `err` change only in the cycle where `done` is high.
- R9: `done` is high for exactly one cycle. It appears 128*`DIV` cycles after the clock edge that accepted the request, and `busy` is high from the accepting edge until `done`.
- R10: A request raised while `busy` is high is ignored. The frame in progress continues unchanged and no additional `done` results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Transaction request strobe, accepted when idle |
| rd_nwr | input | 1 | 1 = register read, 0 = register write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read result, 0 on error or after a write |
| err | output | 1 | No PHY answered the read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data driven toward the PHY |
| mdo_oe | output | 1 | Output-enable for the data pad |
| mdi | input | 1 | Data received from the PHY |

## Verification
The bench builds the block with `DIV` = 2, so each clock phase spans two system cycles. With that value, a phase that is one cycle short or one cycle long shows up in the measured high time of the clock and in the done latency. It also means the PHY model's response bit has to stay stable for a full low phase before the sample is taken. The bench's PHY model answers reads according to how many rising edges it has counted, which puts the error sample and both ends of the data window within reach, along with a request injected in the middle of a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Frame geometry, in clock slots (one slot = one low and one high phase)
  localparam int FRAME_SLOTS = 64;
  localparam int PRE_SLOTS   = 32;
  localparam int TA_SLOT     = 46;   // first slot after the header
  localparam int ERR_SLOT    = 47;   // slot whose low phase yields the error sample
  localparam int DATA_SLOT   = 48;   // first read data slot
  localparam int SLOT_W      = 6;

  localparam logic [1:0] CODE_START = 2'b01;
  localparam logic [1:0] CODE_RD    = 2'b10;
  localparam logic [1:0] CODE_WR    = 2'b01;
  localparam logic [1:0] CODE_TA    = 2'b10;

  // Full serial image of a frame, bit 63 goes out first
  function automatic logic [63:0] build_frame(input logic rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] wd);
    logic [17:0] tail;
    tail = rd ? 18'h0 : {CODE_TA, wd};
    return {32'hFFFF_FFFF, CODE_START, (rd ? CODE_RD : CODE_WR), phy, rg, tail};
  endfunction

  // Result masking: an absent PHY forces a zero result
  function automatic logic [15:0] read_result(input logic rd, input logic e,
                                              input logic [15:0] raw);
    return (rd && !e) ? raw : 16'h0;
  endfunction
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || restart)  cnt <= '0;
    else if (tick)             cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  output logic              busy,
  output logic              hi,
  output logic [SLOT_W-1:0] slot,
  output logic              sample_en,
  output logic              frame_end
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

  assign sample_en = tick && !hi;
  assign frame_end = tick && hi && (slot == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hi   <= 1'b0;
      slot <= '0;
    end else if (start) begin
      busy <= 1'b1;
      hi   <= 1'b0;
      slot <= '0;
    end else if (tick) begin
      if (!hi) begin
        hi <= 1'b1;
      end else begin
        hi <= 1'b0;
        if (slot == LAST_SLOT) begin
          busy <= 1'b0;
          slot <= '0;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_rx.sv
module mdio_rx
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sample_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic              mdi,
  output logic              err_q,
  output logic [15:0]       shift_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      shift_q <= '0;
    end else if (start) begin
      err_q   <= 1'b0;
      shift_q <= '0;
    end else if (sample_en) begin
      if (slot == SLOT_W'(ERR_SLOT))
        err_q <= mdi;
      else if (slot >= SLOT_W'(DATA_SLOT))
        shift_q <= {shift_q[14:0], mdi};
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        rd_nwr,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        err,
  output logic        done,
  output logic        busy,
  output logic        mdc,
  output logic        mdo,
  output logic        mdo_oe,
  input  logic        mdi
);
  logic              start;
  logic              tick;
  logic              hi;
  logic [SLOT_W-1:0] slot_idx;
  logic              sample_en;
  logic              frame_end;
  logic              err_raw;
  logic [15:0]       rx_word;
  logic [63:0]       frame_q;
  logic              rd_q;
  logic              in_hdr;

  assign start = req && !busy;

  mdio_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(start), .tick(tick)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .busy(busy), .hi(hi),
    .slot(slot_idx), .sample_en(sample_en), .frame_end(frame_end)
  );

  mdio_rx u_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_en(sample_en), .slot(slot_idx),
    .mdi(mdi), .err_q(err_raw), .shift_q(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      rd_q    <= 1'b0;
    end else if (start) begin
      frame_q <= build_frame(rd_nwr, phy_addr, reg_addr, wdata);
      rd_q    <= rd_nwr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= frame_end;
      if (frame_end) begin
        rdata <= read_result(rd_q, err_raw, rx_word);
        err   <= rd_q && err_raw;
      end
    end
  end

  assign in_hdr = slot_idx < SLOT_W'(TA_SLOT);
  assign mdc    = busy && hi;
  assign mdo    = busy ? frame_q[SLOT_W'(FRAME_SLOTS - 1) - slot_idx] : 1'b1;
  assign mdo_oe = !busy || !rd_q || in_hdr;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [15:0]       rdata,
  input logic              mdc,
  input logic              mdo,
  input logic              mdo_oe,
  input logic [SLOT_W-1:0] slot_idx
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && mdo && mdo_oe)); // R1

  AST_PRE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot_idx < SLOT_W'(PRE_SLOTS)) |-> (mdo && mdo_oe)); // R2

  AST_EDGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdo) && $stable(mdo_oe))); // R4

  AST_OE_SWITCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdo_oe) |-> !mdc); // R6

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rdata == 16'h0)); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rdata) || !$stable(err)) |-> done); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot_idx != '0) |=> (!busy || slot_idx >= $past(slot_idx))); // R10
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err), .rdata(rdata),
  .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe), .slot_idx(slot_idx)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int LAT        = 128 * DIV;

  // vector: {rd, absent, inject, phy[5], reg[5], data[16]}
  localparam int NV = 7;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 5'h01, 5'h00, 16'hA5C3},
    {1'b1, 1'b0, 1'b0, 5'h03, 5'h02, 16'h1234},
    {1'b1, 1'b1, 1'b0, 5'h05, 5'h04, 16'hBEEF},
    {1'b0, 1'b0, 1'b0, 5'h1F, 5'h1F, 16'hFFFF},
    {1'b1, 1'b0, 1'b0, 5'h00, 5'h01, 16'h8001},
    {1'b0, 1'b0, 1'b1, 5'h0A, 5'h15, 16'h0000},
    {1'b1, 1'b0, 1'b1, 5'h1F, 5'h00, 16'hFFFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic rd_nwr = 1'b0;
  logic [4:0] phy_addr = '0;
  logic [4:0] reg_addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic err, done, busy, mdc, mdo, mdo_oe;
  logic mdi = 1'b1;

  int checks = 0;
  int errors = 0;

  // PHY model state
  int          edge_cnt = 0;
  logic [63:0] cap_bits = '0;
  logic [63:0] cap_oe = '0;
  logic        resp_rd = 1'b0;
  logic        resp_absent = 1'b0;
  logic [15:0] resp_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .rd_nwr(rd_nwr), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata), .err(err), .done(done),
    .busy(busy), .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe), .mdi(mdi)
  );

  function automatic logic phy_bit(input int s);
    if (!resp_rd)      return 1'b1;
    if (s == 47)       return resp_absent;
    if (s >= 48 && s <= 63) return resp_word[63 - s];
    return 1'b1;
  endfunction

  always @(posedge mdc) begin
    cap_bits <= {cap_bits[62:0], mdo_oe ? mdo : 1'b0};
    cap_oe   <= {cap_oe[62:0], mdo_oe};
    edge_cnt <= edge_cnt + 1;
  end

  always @(negedge mdc) mdi = phy_bit(edge_cnt);

  task automatic check(input string req_tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  task automatic check_idle(input string what);
    check("R1", {what, " idle lines"}, {60'h0, mdc, mdo, mdo_oe, busy}, 64'h6);
  endtask

  task automatic run_txn(input logic [28:0] v);
    logic        rd, absent, inject;
    logic [4:0]  pa, ra;
    logic [15:0] dt;
    logic [63:0] exp_frame, exp_oe;
    int cyc, hi_cyc, dones;
    {rd, absent, inject, pa, ra, dt} = v;
    exp_frame = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra,
                 rd ? 18'h0 : {2'b10, dt}};
    exp_oe = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
    edge_cnt = 0; mdi = 1'b1;
    resp_rd = rd; resp_absent = absent; resp_word = dt;
    rd_nwr = rd; phy_addr = pa; reg_addr = ra; wdata = dt; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check("R9", "busy after accept", {63'h0, busy}, 64'h1);
    cyc = 0; hi_cyc = 0; dones = 0;
    while (cyc < LAT + 40) begin
      @(negedge clk);
      cyc++;
      if (mdc) hi_cyc++;
      if (inject && cyc == 60) begin
        rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~dt; req = 1'b1;
      end else if (inject && cyc == 61) begin
        req = 1'b0;
      end
      if (done) begin dones++; break; end
    end
    check("R9", "done latency", 64'(cyc), 64'(LAT));
    check("R2", "rising edges", 64'(edge_cnt), 64'd64);
    check("R2", "preamble bits", cap_bits[63:32] & cap_oe[63:32], 64'hFFFF_FFFF);
    check("R3", "header bits", {50'h0, cap_bits[31:18]}, {50'h0, exp_frame[31:18]});
    check("R4", "mdc high cycles", 64'(hi_cyc), 64'(64 * DIV));
    check(rd ? "R6" : "R5", "output enable per edge", cap_oe, exp_oe);
    if (!rd) check("R5", "write tail", {46'h0, cap_bits[17:0]}, {46'h0, exp_frame[17:0]});
    check(rd ? "R7" : "R8", "rdata", {48'h0, rdata}, {48'h0, (rd && !absent) ? dt : 16'h0});
    check("R8", "err flag", {63'h0, err}, {63'h0, rd && absent});
    check("R6", "oe back at done", {63'h0, mdo_oe}, 64'h1);
    @(negedge clk);
    check("R9", "done width", {63'h0, done}, 64'h0);
    if (inject) begin
      repeat (LAT / 2) @(negedge clk);
      check("R10", "no extra frame or done", {62'h0, busy, done}, 64'h0);
      check("R10", "edges after frame", 64'(edge_cnt), 64'd64);
    end
    check_idle("post-frame");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("after reset");
    check("R8", "reset result", {47'h0, err, rdata}, 64'h0);

    for (int i = 0; i < NV; i++) run_txn(VEC[i]);

    // Reset in the middle of a frame returns the lines to idle (R1)
    rd_nwr = 1'b1; phy_addr = 5'h07; reg_addr = 5'h09; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("mid-frame reset");
    rst_n = 1'b1;
    @(negedge clk);

    // Back-to-back: read error, then a clean write clears err (R8)
    run_txn({1'b1, 1'b1, 1'b0, 5'h12, 5'h0C, 16'h7777});
    run_txn({1'b0, 1'b0, 1'b0, 5'h02, 5'h03, 16'h5A5A});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule